// File: doc/BRIEF.md
# Split-Access 64-bit Register Window

This adapter sits between a 32-bit host port and a bank of 64-bit control registers. The host reaches each wide register through two word accesses. Address bit 2 picks the half, and the address bits above bit 5 pick the register. Registers therefore sit 64 bytes apart. A single 32-bit staging word is shared by both directions. A write to the low half parks its data in that word, and a write to the high half joins the parked word with new data. The joined value reaches the bank as one 64-bit write strobe. A read of the low half fetches the whole register in one 64-bit read strobe. It returns the low 32 bits and parks the high 32 bits in the staging word. A following read of the high half returns them without touching the bank.

Register index 0 is a status register that the adapter holds itself. Its low 16 bits never change after reset. A commit takes new data only where a write mask parameter is set, and clears every other bit above bit 15. Indices at or above the register count are unmapped. Accesses narrower than a word are refused with a one-cycle error pulse. Read data and the error flag are registered, so they appear one cycle after the access. The bank answers reads in the same cycle as the read strobe.

Top module: `wide_reg_window`

## Requirements
- R1: A word write with address bit 2 clear (low half) loads `wdata` into the staging word. It raises no bank strobe and leaves the status register unchanged, including at an unmapped index.
- R2: A word write with address bit 2 set (high half) to mapped index 1..NREG-1 raises `bank_wr` in the same cycle. `bank_wdata` = {wdata, staging word}.
- R3: A word read of the low half at index 1..NREG-1 raises `bank_rd` in the same cycle. On the next cycle `rdata` = bank_rdata[31:0], and the staging word holds bank_rdata[63:32].
- R4: A word read of the high half raises no strobe and changes no state. On the next cycle `rdata` equals the staging word as it stood before the access.
- R5: The register index is addr[ADDR_W-1:6]. Address bits 5:3 and 1:0 have no effect on any access.
- R6: A high-half commit to index 0 sets the status register to (old & 0xFFFF) | ({wdata, staging} & STATUS_MASK). The default mask is 0x0777777fff3f0000. Index 0 never raises a bank strobe, and it reads back through the same two-half sequence.
- R7: An index at or above NREG raises no strobe. A write there changes no register. A low-half read there returns 0 and loads 0 into the staging word.
- R8: An access with `size` other than 2 (0 = byte, 1 = 16-bit, 2 = word) raises no strobe and does not change the staging word or the status register. `err` is 1 on the next cycle and `rdata` is 0. `err` is 0 after any other cycle.
- R9: After reset the staging word is 0, the status register equals STATUS_INIT (default 0x4003), and `rdata` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access valid this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address: index in bits ADDR_W-1:6, half in bit 2 |
| size | input | 2 | 0 byte, 1 16-bit, 2 word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| err | output | 1 | One-cycle pulse after a narrow access |
| bank_idx | output | ADDR_W-6 | Register index presented to the bank |
| bank_rd | output | 1 | 64-bit read strobe |
| bank_wr | output | 1 | 64-bit write strobe |
| bank_wdata | output | 64 | Assembled 64-bit write value |
| bank_rdata | input | 64 | Bank read value for `bank_idx`, same cycle |

## Verification
The assertions check several rules on every cycle. Strobes only fire on the correct half, direction and size, and never for unmapped indices. A low-half write never moves the status register. A high-half read returns the prior staging word and leaves it intact. The low status bits stay at their reset value. A narrow access yields exactly one error cycle with zero data. Only the bench's scenarios can show that the 64-bit value assembled across two accesses lands intact in the bank, and that the status mask is applied. They also show that a low-half read's high word survives for the next access, even when that access is a write. The bench's reference model tracks the bank, the staging word and the status register, and compares every output on every cycle.

// File: rtl/wide_reg_window.sv
module wide_reg_window #(
  parameter int          ADDR_W      = 12,
  parameter int          NREG        = 8,
  parameter logic [63:0] STATUS_INIT = 64'h0000_0000_0000_4003,
  parameter logic [63:0] STATUS_MASK = 64'h0777_777f_ff3f_0000,
  localparam int         IDX_W       = ADDR_W - 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              err,
  output logic [IDX_W-1:0]  bank_idx,
  output logic              bank_rd,
  output logic              bank_wr,
  output logic [63:0]       bank_wdata,
  input  logic [63:0]       bank_rdata
);

  logic [31:0] stage_q;
  logic [63:0] status_q;
  logic        word, hi, mapped, is_st, go;
  logic [63:0] full;

  assign bank_idx   = addr[ADDR_W-1:6];
  assign word       = (size == 2'd2);
  assign hi         = addr[2];
  assign mapped     = (32'(bank_idx) < NREG);
  assign is_st      = (bank_idx == '0);
  assign go         = req & word & mapped;
  assign bank_wr    = go & wr & hi & ~is_st;
  assign bank_rd    = go & ~wr & ~hi & ~is_st;
  assign bank_wdata = {wdata, stage_q};
  assign full       = !mapped ? 64'd0 : (is_st ? status_q : bank_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= '0;
      status_q <= STATUS_INIT;
      rdata    <= '0;
      err      <= 1'b0;
    end else begin
      err <= req & ~word;
      if (req) begin
        if (!word) begin
          rdata <= '0;
        end else if (wr) begin
          if (!hi)
            stage_q <= wdata;
          else if (go && is_st)
            status_q <= (status_q & 64'hFFFF) | (bank_wdata & STATUS_MASK);
        end else if (!hi) begin
          rdata   <= full[31:0];
          stage_q <= full[63:32];
        end else begin
          rdata <= stage_q;
        end
      end
    end
  end

endmodule

// File: rtl/wide_reg_window_chk.sv
module wide_reg_window_chk #(
  parameter int          ADDR_W      = 12,
  parameter int          NREG        = 8,
  parameter logic [63:0] STATUS_INIT = 64'h0000_0000_0000_4003
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        size,
  input logic [31:0]       rdata,
  input logic              err,
  input logic              bank_rd,
  input logic              bank_wr,
  input logic [31:0]       stage_q,
  input logic [63:0]       status_q
);

  logic narrow, unmapped;
  assign narrow   = req && (size != 2'd2);
  assign unmapped = 32'(addr[ADDR_W-1:6]) >= NREG;

  AST_LOW_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr && !addr[2]) |-> !bank_wr); // R1
  AST_LOW_WRITE_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr && !addr[2]) |=> $stable(status_q)); // R1
  AST_COMMIT_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |-> (req && wr && addr[2] && size == 2'd2)); // R2
  AST_FETCH_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd |-> (req && !wr && !addr[2] && size == 2'd2)); // R3
  AST_HIGH_READ_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && addr[2] && size == 2'd2) |=> (rdata == $past(stage_q) && $stable(stage_q))); // R4
  AST_STATUS_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[15:0] == STATUS_INIT[15:0]); // R6
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req && unmapped) |-> (!bank_wr && !bank_rd)); // R7
  AST_NARROW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |=> (err && rdata == 32'd0 && $stable(stage_q) && $stable(status_q))); // R8
  AST_ERR_ONLY_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    !narrow |=> !err); // R8

endmodule

bind wide_reg_window wide_reg_window_chk #(
  .ADDR_W(ADDR_W), .NREG(NREG), .STATUS_INIT(STATUS_INIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .size(size),
  .rdata(rdata), .err(err), .bank_rd(bank_rd), .bank_wr(bank_wr),
  .stage_q(stage_q), .status_q(status_q)
);

// File: tb/wide_reg_window_bench.sv
`timescale 1ns/1ps
module wide_reg_window_bench;
  localparam int          AW    = 12;
  localparam int          NR    = 8;
  localparam int          IW    = AW - 6;
  localparam logic [63:0] SINIT = 64'h0000_0000_0000_4003;
  localparam logic [63:0] SMASK = 64'h0777_777f_ff3f_0000;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    size = 2'd2;
  logic [31:0]   wdata = '0, rdata;
  logic          err, bank_rd, bank_wr;
  logic [IW-1:0] bank_idx;
  logic [63:0]   bank_wdata, bank_rdata;

  always #2.5 clk = ~clk;

  wide_reg_window u_wide_reg_window (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .size(size),
    .wdata(wdata), .rdata(rdata), .err(err), .bank_idx(bank_idx),
    .bank_rd(bank_rd), .bank_wr(bank_wr), .bank_wdata(bank_wdata),
    .bank_rdata(bank_rdata)
  );

  logic [63:0] bank_mem [64];
  assign bank_rdata = bank_mem[bank_idx];
  always @(posedge clk) if (bank_wr) bank_mem[bank_idx] <= bank_wdata;

  logic [63:0] m_mem [NR];
  logic [63:0] m_status = SINIT;
  logic [31:0] m_stage = '0, exp_rdata = '0;
  logic        exp_err = 1'b0;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int idx, input bit hi, input int junk);
    return AW'((idx << 6) | (int'(hi) << 2) | (junk & 'h3b));
  endfunction

  task automatic cyc(input bit r, input bit w, input logic [AW-1:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input string tag);
    int idx; bit mp, ewr, erd; logic [63:0] v, full;
    @(negedge clk);
    chk(tag, "rdata", rdata, exp_rdata);
    chk(tag, "err", err, exp_err);
    req = r; wr = w; addr = a; size = sz; wdata = d;
    #1;
    idx = int'(a >> 6);
    mp  = idx < NR;
    ewr = r && w && sz == 2 && a[2] && mp && idx != 0;
    erd = r && !w && sz == 2 && !a[2] && mp && idx != 0;
    chk(tag, "bank_wr", bank_wr, ewr);
    chk(tag, "bank_rd", bank_rd, erd);
    v = {d, m_stage};
    if (ewr) begin
      chk(tag, "bank_wdata", bank_wdata, v);
      chk(tag, "bank_idx", bank_idx, idx);
    end
    exp_err = r && sz != 2;
    if (r) begin
      if (sz != 2) exp_rdata = 0;
      else if (w) begin
        if (!a[2]) m_stage = d;
        else if (mp && idx == 0) m_status = (m_status & 64'hFFFF) | (v & SMASK);
        else if (mp) m_mem[idx] = v;
      end else if (!a[2]) begin
        full = !mp ? 64'd0 : (idx == 0 ? m_status : m_mem[idx]);
        exp_rdata = full[31:0];
        m_stage = full[63:32];
      end else exp_rdata = m_stage;
    end
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, '0, 2'd2, 32'd0, tag);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bank_mem[i] = {32'hA5000000 + i, 32'h5A000000 + 7 * i};
    for (int i = 0; i < NR; i++) m_mem[i] = {32'hA5000000 + i, 32'h5A000000 + 7 * i};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R9");
    cyc(1, 0, mk(3, 1, 0), 2'd2, 0, "R9");
    idle("R9");
    for (int i = 1; i < NR; i++) begin
      cyc(1, 1, mk(i, 0, 0), 2'd2, 32'h1000_0000 + i, "R1");
      cyc(1, 1, mk(i, 1, 0), 2'd2, 32'hC0DE_0000 + i, "R2");
    end
    for (int i = 1; i < NR; i++) begin
      cyc(1, 0, mk(i, 0, 0), 2'd2, 0, "R3");
      cyc(1, 0, mk(i, 1, 0), 2'd2, 0, "R4");
      cyc(1, 0, mk(i, 1, 0), 2'd2, 0, "R4");
    end
    cyc(1, 0, mk(2, 0, 0), 2'd2, 0, "R3");
    cyc(1, 1, mk(2, 1, 0), 2'd2, 32'h7777_8888, "R3");
    cyc(1, 0, mk(5, 0, 'h3b), 2'd2, 0, "R5");
    cyc(1, 1, mk(5, 0, 'h29), 2'd2, 32'h1234_5678, "R5");
    cyc(1, 1, mk(5, 1, 'h13), 2'd2, 32'h9abc_def0, "R5");
    cyc(1, 0, mk(5, 0, 'h08), 2'd2, 0, "R5");
    cyc(1, 0, mk(5, 1, 'h3b), 2'd2, 0, "R5");
    cyc(1, 0, mk(0, 0, 0), 2'd2, 0, "R6");
    cyc(1, 0, mk(0, 1, 0), 2'd2, 0, "R6");
    cyc(1, 1, mk(0, 0, 0), 2'd2, 32'hFFFF_FFFF, "R6");
    cyc(1, 1, mk(0, 1, 0), 2'd2, 32'hFFFF_FFFF, "R6");
    cyc(1, 0, mk(0, 0, 0), 2'd2, 0, "R6");
    cyc(1, 0, mk(0, 1, 0), 2'd2, 0, "R6");
    cyc(1, 1, mk(0, 0, 0), 2'd2, 32'h0001_2345, "R6");
    cyc(1, 1, mk(0, 1, 0), 2'd2, 32'h0, "R6");
    cyc(1, 0, mk(0, 0, 0), 2'd2, 0, "R6");
    cyc(1, 0, mk(0, 1, 0), 2'd2, 0, "R6");
    for (int i = NR; i < 64; i += 13) begin
      cyc(1, 1, mk(i, 0, 0), 2'd2, 32'h5555_0000 + i, "R7");
      cyc(1, 1, mk(i, 1, 0), 2'd2, 32'h6666_0000 + i, "R7");
      cyc(1, 0, mk(i, 0, 0), 2'd2, 0, "R7");
      cyc(1, 0, mk(i, 1, 0), 2'd2, 0, "R7");
    end
    cyc(1, 0, mk(4, 0, 0), 2'd2, 0, "R8");
    cyc(1, 1, mk(4, 0, 0), 2'd0, 32'hDEAD_BEEF, "R8");
    cyc(1, 1, mk(4, 1, 0), 2'd1, 32'hDEAD_BEEF, "R8");
    cyc(1, 0, mk(4, 0, 0), 2'd1, 0, "R8");
    cyc(1, 0, mk(0, 1, 0), 2'd0, 0, "R8");
    cyc(1, 0, mk(4, 1, 0), 2'd2, 0, "R8");
    cyc(1, 0, mk(0, 0, 0), 2'd2, 0, "R8");
    idle("R8");
    for (int n = 0; n < 400; n++) begin
      int unsigned rv = $urandom;
      cyc(1, rv[0], mk(int'(rv[7:1] % 10), rv[8], int'(rv[14:9])),
          (rv[17:15] == 0) ? 2'(rv[19:18] % 2) : 2'd2, $urandom, "mixed");
    end
    idle("mixed");
    idle("mixed");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule